// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block is a byte-wide register-mapped controller for an external 10-bit successive-approximation converter with eight analog inputs. Software programs an inclusive channel window (first and last channel), picks one of four trigger sources (software, either of two timer pulses, or an active-low external pin), chooses one pass or endless repetition, and sets the length of the sampling window in clocks.

Once armed and triggered, the sequencer walks the channel window one channel at a time. For each channel it holds a sample strobe for the programmed window, pulses a convert request, and waits for the converter's done strobe. It then latches the 10-bit value into a result register that is split over two byte addresses. A completion flag tells software a fresh value is waiting and clears when the low result byte is read. A sticky overwrite flag records any value that replaced one nobody had read, and only software can clear it.

Top module: `adc_scan_seq`

Register addresses: 0 result bits 7:0; 1 result bits 9:8 in bits 1:0; 2 trigger/mode; 3 channel window; 4 control/status; 5 sampling time. Reads return data one clock after the read strobe, and return 0 when no read is strobed.

## Requirements
- R1: After reset, addresses 0 to 4 and any unmapped address read 0x00, and address 5 reads 0x03.
- R2: Field placement. Address 2 has continuous mode at bit 5, trigger source at bits 4:3 and the current channel (read-only) at bits 2:0. Address 3 has the last channel at bits 5:3 and the first channel at bits 2:0. Address 4 has the completion flag at bit 3 (read-only), enable at bit 2, run at bit 1 and overwrite error at bit 0. Address 5 has the sampling code at bits 1:0. All other bits read 0.
- R3: Address 0 returns result bits 7:0. Address 1 returns result bits 9:8 in bits 1:0 with bits 7:2 at 0.
- R4: The sampling code selects how many clocks the sample strobe stays high: 00 gives 3, 01 gives 5, 10 gives 7, 11 gives 9. The next clock carries a convert request exactly one clock long.
- R5: A scan starts at the first channel and moves up one channel at a time, wrapping from 7 to 0, until it reaches the last channel. The channel output names the channel being converted. In single-pass mode, run clears when the last channel's result is latched.
- R6: In continuous mode, the scan restarts at the first channel after the last one without a new trigger. Writing 0 to run returns the sequencer to idle within two clocks, with both strobes low.
- R7: With trigger code 00 (software), the sample strobe rises on the second clock after the write that sets run.
- R8: With trigger code 10 (8-bit timer) or 01 (16-bit timer), a set run bit waits until a pulse arrives on the selected timer input. Pulses on the other timer input are ignored.
- R9: With trigger code 11, the pin passes through a two-stage synchronizer. A falling edge starts sampling on the third clock edge after the pin goes low.
- R10: The completion flag sets when a result is latched and clears when address 0 is read.
- R11: If a result is latched while the completion flag is set and address 0 is not being read in that clock, the overwrite flag sets and the new value replaces the old one. The overwrite flag clears only when 0 is written to bit 0 of address 4. Writing 1 there has no effect.
- R12: Run can be set only in a write that also sets enable. Writing enable to 0 clears run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after bus_rd |
| trig_pin_n | input | 1 | Asynchronous external trigger, falling edge active |
| tmr8_pulse | input | 1 | One-clock trigger pulse from the 8-bit timer |
| tmr16_pulse | input | 1 | One-clock trigger pulse from the 16-bit timer |
| cv_sample | output | 1 | Sample strobe to the converter |
| cv_start | output | 1 | One-clock convert request |
| cv_chan | output | 3 | Channel currently selected |
| cv_done | input | 1 | Converter result strobe |
| cv_value | input | 10 | Converter result |

## Verification
The hardest state to reach is the collision between a latched result and the completion flag. That case depends on software not reading the low byte between two converter done strobes, and on reads landing in particular clocks while a continuous scan runs. The bench reaches it by letting whole scans finish unread, and by reading during a continuous two-channel scan. A behavioural model follows every clock and keeps the flag, overwrite and read-data timing in step with the design. Trigger latency is reached by driving timer pulses and pin edges at known clocks and checking the strobe at the exact edge where it must rise.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ARM  = 3'd1,
    S_SAMP = 3'd2,
    S_CONV = 3'd3,
    S_WAIT = 3'd4
  } scan_state_e;

  // trigger source codes (bits 4:3 of the trigger/mode register)
  localparam logic [1:0] TRG_SW   = 2'b00;
  localparam logic [1:0] TRG_T16  = 2'b01;
  localparam logic [1:0] TRG_T8   = 2'b10;
  localparam logic [1:0] TRG_PIN  = 2'b11;

  // register addresses
  localparam int RA_RES_LO = 0;
  localparam int RA_RES_HI = 1;
  localparam int RA_TRIG   = 2;
  localparam int RA_CHAN   = 3;
  localparam int RA_CTRL   = 4;
  localparam int RA_SAMP   = 5;

  // bit positions that software relies on
  localparam int B_MODE  = 5;
  localparam int B_TRG   = 3;
  localparam int B_EN    = 2;
  localparam int B_RUN   = 1;
  localparam int B_OWE   = 0;

  localparam logic [1:0] SAMP_RESET = 2'b11;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_scan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src,
  input  logic       pin_n,
  input  logic       tmr8,
  input  logic       tmr16,
  output logic       fire
);

  // shift chain: SYNC_STAGES synchronizer flops plus one history flop
  logic [SYNC_STAGES:0] sh;
  logic                 pin_fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC_STAGES-1:0], pin_n};
  end

  assign pin_fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

  always_comb begin
    case (src)
      TRG_SW:  fire = 1'b1;
      TRG_T16: fire = tmr16;
      TRG_T8:  fire = tmr8;
      default: fire = pin_fall;
    endcase
  end

  p_pin_single_r9: assert property (@(posedge clk) disable iff (rst)
    (src == TRG_PIN && fire) |=> !(src == TRG_PIN && fire));

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int RES_W     = 10,
  parameter int SAMP_BASE = 3,
  parameter int SAMP_STEP = 2,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             mode_cont,
  input  logic [CH_W-1:0]  start_ch,
  input  logic [CH_W-1:0]  end_ch,
  input  logic [1:0]       samp_code,
  input  logic             fire,
  input  logic             cv_done,
  input  logic [RES_W-1:0] cv_value,
  output logic             cv_sample,
  output logic             cv_start,
  output logic [CH_W-1:0]  cv_chan,
  output logic             res_we,
  output logic [RES_W-1:0] res_val,
  output logic             scan_end
);

  scan_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] samp_len;
  logic [CH_W-1:0]  ch;
  logic             at_last;

  assign samp_len = CNT_W'(SAMP_BASE) + CNT_W'(SAMP_STEP) * CNT_W'(samp_code);
  assign at_last  = (ch == end_ch);
  assign res_we   = run && (state == S_WAIT) && cv_done;
  assign res_val  = cv_value;
  assign scan_end = res_we && at_last && !mode_cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      ch    <= '0;
    end else if (!run) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: state <= S_ARM;
        S_ARM: if (fire) begin
          state <= S_SAMP;
          ch    <= start_ch;
          cnt   <= '0;
        end
        S_SAMP: begin
          if (cnt == samp_len - 1'b1) begin
            state <= S_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CONV: state <= S_WAIT;
        S_WAIT: if (cv_done) begin
          cnt <= '0;
          if (!at_last) begin
            ch    <= ch + 1'b1;
            state <= S_SAMP;
          end else if (mode_cont) begin
            ch    <= start_ch;
            state <= S_SAMP;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cv_sample = (state == S_SAMP);
  assign cv_start  = (state == S_CONV);
  assign cv_chan   = ch;

  p_conv_after_samp_r4: assert property (@(posedge clk) disable iff (rst)
    cv_start |-> $past(cv_sample));
  p_conv_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
    cv_start |=> !cv_start);
  p_no_strobe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !(cv_sample || cv_start));

endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              res_we,
  input  logic [RES_W-1:0]  res_val,
  input  logic              scan_end,
  input  logic [CH_W-1:0]   cur_ch,
  output logic              mode_cont,
  output logic [1:0]        trig_src,
  output logic [CH_W-1:0]   start_ch,
  output logic [CH_W-1:0]   end_ch,
  output logic [1:0]        samp_code,
  output logic              run
);

  localparam int HI_W = RES_W - DATA_W;

  logic             mode_q, en_q, run_q, flag_q, owe_q;
  logic [1:0]       trg_q, samp_q;
  logic [CH_W-1:0]  start_q, end_q;
  logic [RES_W-1:0] res_q;
  logic [DATA_W-1:0] rd_mux;
  logic wr_trig, wr_chan, wr_ctrl, wr_samp, rd_lo;

  assign wr_trig = wr && (addr == ADDR_W'(RA_TRIG));
  assign wr_chan = wr && (addr == ADDR_W'(RA_CHAN));
  assign wr_ctrl = wr && (addr == ADDR_W'(RA_CTRL));
  assign wr_samp = wr && (addr == ADDR_W'(RA_SAMP));
  assign rd_lo   = rd && (addr == ADDR_W'(RA_RES_LO));

  always_comb begin
    case (int'(addr))
      RA_RES_LO: rd_mux = res_q[DATA_W-1:0];
      RA_RES_HI: rd_mux = DATA_W'(res_q[RES_W-1 -: HI_W]);
      RA_TRIG:   rd_mux = DATA_W'({mode_q, trg_q, cur_ch});
      RA_CHAN:   rd_mux = DATA_W'({end_q, start_q});
      RA_CTRL:   rd_mux = DATA_W'({flag_q, en_q, run_q, owe_q});
      RA_SAMP:   rd_mux = DATA_W'(samp_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      trg_q   <= TRG_SW;
      start_q <= '0;
      end_q   <= '0;
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      owe_q   <= 1'b0;
      samp_q  <= SAMP_RESET;
      res_q   <= '0;
      rdata   <= '0;
    end else begin
      if (wr_trig) begin
        mode_q <= wdata[B_MODE];
        trg_q  <= wdata[B_TRG +: 2];
      end
      if (wr_chan) begin
        end_q   <= wdata[CH_W +: CH_W];
        start_q <= wdata[CH_W-1:0];
      end
      if (wr_samp) samp_q <= wdata[1:0];
      if (wr_ctrl) begin
        en_q  <= wdata[B_EN];
        run_q <= wdata[B_EN] & wdata[B_RUN];
      end else if (scan_end) begin
        run_q <= 1'b0;
      end
      if (res_we && flag_q && !rd_lo)       owe_q <= 1'b1;
      else if (wr_ctrl && !wdata[B_OWE])    owe_q <= 1'b0;
      if (res_we)     flag_q <= 1'b1;
      else if (rd_lo) flag_q <= 1'b0;
      if (res_we) res_q <= res_val;
      rdata <= rd ? rd_mux : '0;
    end
  end

  assign mode_cont = mode_q;
  assign trig_src  = trg_q;
  assign start_ch  = start_q;
  assign end_ch    = end_q;
  assign samp_code = samp_q;
  assign run       = run_q;

  p_owe_needs_flag_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(owe_q) |-> $past(flag_q));
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !res_we) |=> !flag_q);
  p_run_needs_en_r12: assert property (@(posedge clk) disable iff (rst)
    run_q |-> en_q);
  p_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(RA_RES_HI)) |=> (rdata[DATA_W-1:HI_W] == '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int RES_W       = 10,
  parameter int CH_N        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SAMP_BASE   = 3,
  parameter int SAMP_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              trig_pin_n,
  input  logic              tmr8_pulse,
  input  logic              tmr16_pulse,
  output logic              cv_sample,
  output logic              cv_start,
  output logic [$clog2(CH_N)-1:0] cv_chan,
  input  logic              cv_done,
  input  logic [RES_W-1:0]  cv_value
);

  localparam int CH_W  = $clog2(CH_N);
  localparam int CNT_W = $clog2(SAMP_BASE + 3 * SAMP_STEP + 1) + 1;

  logic             mode_cont, run, fire, res_we, scan_end;
  logic [1:0]       trig_src, samp_code;
  logic [CH_W-1:0]  start_ch, end_ch;
  logic [RES_W-1:0] res_val;

  adc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W), .CH_W(CH_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .res_we(res_we), .res_val(res_val),
    .scan_end(scan_end), .cur_ch(cv_chan), .mode_cont(mode_cont),
    .trig_src(trig_src), .start_ch(start_ch), .end_ch(end_ch),
    .samp_code(samp_code), .run(run)
  );

  adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .src(trig_src), .pin_n(trig_pin_n),
    .tmr8(tmr8_pulse), .tmr16(tmr16_pulse), .fire(fire)
  );

  adc_scan_fsm #(
    .CH_W(CH_W), .RES_W(RES_W), .SAMP_BASE(SAMP_BASE),
    .SAMP_STEP(SAMP_STEP), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .run(run), .mode_cont(mode_cont),
    .start_ch(start_ch), .end_ch(end_ch), .samp_code(samp_code),
    .fire(fire), .cv_done(cv_done), .cv_value(cv_value),
    .cv_sample(cv_sample), .cv_start(cv_start), .cv_chan(cv_chan),
    .res_we(res_we), .res_val(res_val), .scan_end(scan_end)
  );

endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       trig_pin_n = 1'b1, tmr8_pulse = 1'b0, tmr16_pulse = 1'b0;
  logic       cv_sample, cv_start;
  logic [2:0] cv_chan;
  logic       cv_done = 1'b0;
  logic [9:0] cv_value = '0;

  int vectors = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_pin_n(trig_pin_n),
    .tmr8_pulse(tmr8_pulse), .tmr16_pulse(tmr16_pulse), .cv_sample(cv_sample),
    .cv_start(cv_start), .cv_chan(cv_chan), .cv_done(cv_done), .cv_value(cv_value)
  );

  // converter stub: answers each convert request three clocks later
  int stub_cnt = 0, stub_seq = 0, last_val = 0, stub_ch = 0;
  always @(negedge clk) begin
    cv_done <= 1'b0;
    if (stub_cnt == 1) begin
      cv_done  <= 1'b1;
      cv_value <= 10'((stub_ch * 131 + stub_seq * 53 + 300) % 1024);
      last_val <= (stub_ch * 131 + stub_seq * 53 + 300) % 1024;
      stub_seq <= stub_seq + 1;
    end
    if (cv_start) begin
      stub_cnt <= 3;
      stub_ch  <= int'(cv_chan);
    end else if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
    end
  end

  // observation helpers
  int chlog[$];
  int run_len = 0, last_samp_len = 0;
  always @(negedge clk) begin
    if (cv_start) chlog.push_back(int'(cv_chan));
    if (cv_sample) run_len++;
    else if (run_len != 0) begin
      last_samp_len = run_len;
      run_len = 0;
    end
  end

  // behavioural reference model, advanced on each rising edge
  int m_st, m_cnt, m_ch, m_run, m_en, m_mode, m_trg, m_start, m_end, m_samp;
  int m_flag, m_owe, m_res, m_rdata, m_s1, m_s2, m_s3;
  always @(posedge clk) begin : model
    int fire, we, send, nst, ncnt, nch, rdlo, mux, a, d;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_ch = 0; m_run = 0; m_en = 0; m_mode = 0; m_trg = 0;
      m_start = 0; m_end = 0; m_samp = 3; m_flag = 0; m_owe = 0; m_res = 0;
      m_rdata = 0; m_s1 = 1; m_s2 = 1; m_s3 = 1;
    end else begin
      a = int'(bus_addr); d = int'(bus_wdata);
      case (m_trg)
        0: fire = 1;
        1: fire = int'(tmr16_pulse);
        2: fire = int'(tmr8_pulse);
        default: fire = (m_s3 == 1 && m_s2 == 0) ? 1 : 0;
      endcase
      we = 0; send = 0; nst = m_st; ncnt = m_cnt; nch = m_ch;
      if (m_run == 0) nst = 0;
      else case (m_st)
        0: nst = 1;
        1: if (fire != 0) begin nst = 2; nch = m_start; ncnt = 0; end
        2: if (m_cnt == 3 + 2 * m_samp - 1) begin nst = 3; ncnt = 0; end
           else ncnt = m_cnt + 1;
        3: nst = 4;
        default: if (cv_done) begin
          we = 1; ncnt = 0;
          if (m_ch != m_end) begin nch = (m_ch + 1) % 8; nst = 2; end
          else if (m_mode != 0) begin nch = m_start; nst = 2; end
          else begin nst = 0; send = 1; end
        end
      endcase
      rdlo = (bus_rd && a == 0) ? 1 : 0;
      case (a)
        0: mux = m_res % 256;
        1: mux = m_res / 256;
        2: mux = m_mode * 32 + m_trg * 8 + m_ch;
        3: mux = m_end * 8 + m_start;
        4: mux = m_flag * 8 + m_en * 4 + m_run * 2 + m_owe;
        5: mux = m_samp;
        default: mux = 0;
      endcase
      m_rdata = bus_rd ? mux : 0;
      if (we != 0 && m_flag != 0 && rdlo == 0) m_owe = 1;
      else if (bus_wr && a == 4 && (d % 2) == 0) m_owe = 0;
      if (we != 0) begin m_flag = 1; m_res = int'(cv_value); end
      else if (rdlo != 0) m_flag = 0;
      if (bus_wr && a == 2) begin m_mode = (d / 32) % 2; m_trg = (d / 8) % 4; end
      if (bus_wr && a == 3) begin m_end = (d / 8) % 8; m_start = d % 8; end
      if (bus_wr && a == 5) m_samp = d % 4;
      if (bus_wr && a == 4) begin m_en = (d / 4) % 2; m_run = m_en * ((d / 2) % 2); end
      else if (send != 0) m_run = 0;
      m_st = nst; m_cnt = ncnt; m_ch = nch;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(trig_pin_n);
    end
  end

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      vectors++;
      if (int'(cv_sample) != (m_st == 2 ? 1 : 0)) begin
        errors++; $display("FAIL R4 cv_sample act=%0d exp=%0d t=%0t", cv_sample, m_st == 2, $time);
      end
      if (int'(cv_start) != (m_st == 3 ? 1 : 0)) begin
        errors++; $display("FAIL R4 cv_start act=%0d exp=%0d t=%0t", cv_start, m_st == 3, $time);
      end
      if (int'(cv_chan) != m_ch) begin
        errors++; $display("FAIL R5 cv_chan act=%0d exp=%0d t=%0t", cv_chan, m_ch, $time);
      end
      if (int'(bus_rdata) != m_rdata) begin
        errors++; $display("FAIL R2 rdata act=%0h exp=%0h t=%0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    int d;
    for (int i = 0; i < 400; i++) begin
      rd(4, d);
      if ((d & 2) == 0) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      finish_run();
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk("R1 reset read", d, a == 5 ? 3 : 0);
    end
    // single pass, channels 1..3, software trigger, 3-clock sampling
    wr(3, 8'h19);
    rd(3, d); chk("R2 channel readback", d, 8'h19);
    wr(5, 0);
    wr(2, 8'h00);
    chlog.delete();
    wr(4, 8'h06);
    wait_idle();
    rd(4, d); chk("R11 owe set after unread results", d, 8'h0D);
    rd(2, d); chk("R5 last channel shown", d, 8'h03);
    chk("R4 3-clock sampling", last_samp_len, 3);
    rd(1, d); chk("R3 high bits", d, last_val / 256);
    rd(0, d); chk("R3 low byte", d, last_val % 256);
    rd(4, d); chk("R10 flag cleared by read", d, 8'h05);
    wr(4, 8'h05);
    rd(4, d); chk("R11 writing 1 keeps owe", d, 8'h05);
    wr(4, 8'h04);
    rd(4, d); chk("R11 writing 0 clears owe", d, 8'h04);
    // R12 run needs enable
    wr(4, 8'h00);
    wr(4, 8'h02);
    rd(4, d); chk("R12 run without enable", d, 8'h00);
    // 8-bit timer trigger, single channel 2, 9-clock sampling
    wr(5, 3); wr(3, 8'h12); wr(2, 8'h10);
    chlog.delete();
    wr(4, 8'h06);
    repeat (5) @(negedge clk);
    chk("R8 armed waits", int'(cv_sample), 0);
    tmr16_pulse = 1'b1; @(negedge clk); tmr16_pulse = 1'b0;
    @(negedge clk);
    chk("R8 other timer ignored", int'(cv_sample), 0);
    tmr8_pulse = 1'b1; @(negedge clk); tmr8_pulse = 1'b0;
    chk("R8 selected timer starts", int'(cv_sample), 1);
    wait_idle();
    chk("R4 9-clock sampling", last_samp_len, 9);
    chk("R5 single channel count", chlog.size(), 1);
    // external pin, window 6..1 wrapping, 5-clock sampling
    wr(5, 1);
    rd(5, d); chk("R2 sampling readback", d, 1);
    wr(3, 8'h0E); wr(2, 8'h18);
    chlog.delete();
    wr(4, 8'h06);
    @(negedge clk); trig_pin_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 not yet after two edges", int'(cv_sample), 0);
    @(negedge clk);
    chk("R9 starts on third edge", int'(cv_sample), 1);
    trig_pin_n = 1'b1;
    wait_idle();
    chk("R4 5-clock sampling", last_samp_len, 5);
    chk("R5 wrap scan length", chlog.size(), 4);
    if (chlog.size() == 4) begin
      chk("R5 order 0", chlog[0], 6); chk("R5 order 1", chlog[1], 7);
      chk("R5 order 2", chlog[2], 0); chk("R5 order 3", chlog[3], 1);
    end
    // continuous, software trigger, channels 0..1
    wr(5, 0); wr(3, 8'h08); wr(2, 8'h20);
    chlog.delete();
    wr(4, 8'h06);
    @(negedge clk);
    chk("R7 not on first clock", int'(cv_sample), 0);
    @(negedge clk);
    chk("R7 sampling on second clock", int'(cv_sample), 1);
    for (int i = 0; i < 300 && chlog.size() < 5; i++) begin
      if (i % 7 == 0) rd(0, d); else @(negedge clk);
    end
    chk("R6 enough conversions", int'(chlog.size() >= 5), 1);
    if (chlog.size() >= 5)
      for (int i = 0; i < 5; i++) chk("R6 continuous order", chlog[i], i % 2);
    wr(4, 8'h04);
    @(negedge clk); @(negedge clk);
    chk("R6 stopped sample", int'(cv_sample), 0);
    chk("R6 stopped start", int'(cv_start), 0);
    rd(4, d); chk("R6 run cleared", d & 2, 0);
    rd(0, d);
    rd(4, d); chk("R10 flag clear after read", d & 8, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule